// File: doc/BRIEF.md
# Two-Phase System Bus Master

This block sits on the processor side of a shared parallel bus. It turns a single request into one read or one write on a bus of address lines, data lines and active-low control lines. A request carries an address, write data, a direction flag and a space flag. The space flag separates isolated I/O from ordinary memory. Memory-mapped peripherals are reached as plain memory with the space flag cleared. Each transfer has a fixed length, and when it ends the block raises a one-cycle completion pulse. For a read, the captured data is then presented on `rd_data`.

The sequencer has four named states. `ST_IDLE` leaves the bus quiet and waits. The transition *accept* goes from `ST_IDLE` to `ST_ADDR` when `req_valid` is sampled high. `ST_ADDR` drives the address and the space qualifier, and for a write it also drives the data. The transition *strobe* always goes from `ST_ADDR` to `ST_STRB`. `ST_STRB` keeps the address and data on the bus and pulls the read or write strobe low. A read samples the incoming data at the edge that closes this state. The transition *release* goes from `ST_STRB` to `ST_DONE`. `ST_DONE` has all lines removed and raises `done`. The transition *retire* goes from `ST_DONE` to `ST_IDLE`. A transfer occupies the three cycles after the accepting edge.

Top module: `sysbus_master`

## Requirements
- R1: After reset, and in every idle cycle, `bus_rd_n` and `bus_wr_n` are 1, `bus_doe` is 0, `bus_addr` and `bus_dout` are 0, `bus_io_m` is 0, and `busy` and `done` are 0.
- R2: For a read accepted at edge k: in the cycle after edge k, `bus_addr` shows the request address and both strobes are high. In the next cycle `bus_rd_n` is 0 and the same address is still driven.
- R3: The value on `bus_din` at the edge that closes the low-`bus_rd_n` cycle appears on `rd_data` in the following cycle. In that cycle `done` is 1, `bus_rd_n` is 1 and `bus_addr` is 0.
- R4: For a write, `bus_dout` carries the write data and `bus_doe` is 1 in both the address cycle and the strobe cycle. `bus_wr_n` is 0 only in the strobe cycle. In the done cycle, address, data, enable and strobe are all removed.
- R5: `bus_io_m` is 1 for a transfer requested with `req_io`=1 and 0 for `req_io`=0. It holds that value in both driven cycles of the transfer.
- R6: `bus_rd_n` and `bus_wr_n` are never 0 in the same cycle.
- R7: `busy` is 1 for exactly the three cycles from the address cycle through the done cycle. `done` is 1 only in the last of them.
- R8: `req_valid` and the request fields are ignored while `busy` is 1: the running transfer keeps its address, direction and data, and no extra transfer follows.
- R9: A write transfer leaves `rd_data` unchanged.
- R10: `bus_doe` is 1 only in the address and strobe cycles of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = isolated I/O space, 0 = memory space |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Data from the last read |
| bus_addr | output | ADDR_W | Address lines, 0 when released |
| bus_dout | output | DATA_W | Outgoing data lines, 0 when not driving |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | DATA_W | Incoming data lines |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_io_m | output | 1 | Space qualifier: 1 = I/O, 0 = memory |

## Verification
The bench builds the block with `ADDR_W`=4 and `DATA_W`=8. With a 4-bit address, every location in both spaces can be read and written in both directions, so the complete transfer matrix is covered. The responder's contents are computed from the address and are distinct in the two spaces. A capture one cycle early or late therefore shows up as a wrong value, and so does a write or read in the wrong space. Eight-bit data keeps the arithmetic patterns distinct per location.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_STRB = 2'd2,
        ST_DONE = 2'd3
    } bus_state_t;
endpackage

// File: rtl/sysbus_fsm.sv
module sysbus_fsm
    import sysbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic is_write,
    output logic accept,
    output logic busy,
    output logic done,
    output logic rd_n,
    output logic wr_n,
    output logic drive_addr,
    output logic doe,
    output logic capture
);
    bus_state_t state, state_nx;

    assign accept = (state == ST_IDLE) && req_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_ADDR;
            ST_ADDR: state_nx = ST_STRB;
            ST_STRB: state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy       = 1'b1;
        done       = 1'b0;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        drive_addr = 1'b0;
        doe        = 1'b0;
        capture    = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_ADDR: begin
                drive_addr = 1'b1;
                doe        = is_write;
            end
            ST_STRB: begin
                drive_addr = 1'b1;
                doe        = is_write;
                rd_n       = is_write;
                wr_n       = !is_write;
                capture    = !is_write;
            end
            ST_DONE: done = 1'b1;
        endcase
    end
endmodule

// File: rtl/sysbus_hold.sv
module sysbus_hold #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_write,
    input  logic              in_io,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              held_write,
    output logic              held_io,
    output logic [ADDR_W-1:0] held_addr,
    output logic [DATA_W-1:0] held_wdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_write <= 1'b0;
            held_io    <= 1'b0;
            held_addr  <= '0;
            held_wdata <= '0;
        end else if (load) begin
            held_write <= in_write;
            held_io    <= in_io;
            held_addr  <= in_addr;
            held_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/sysbus_rdcap.sv
module sysbus_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dout <= '0;
        else if (capture) dout <= din;
    end
endmodule

// File: rtl/sysbus_master.sv
module sysbus_master #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_io_m
);
    logic              accept, drive_addr, capture, doe_i;
    logic              held_write, held_io;
    logic [ADDR_W-1:0] held_addr;
    logic [DATA_W-1:0] held_wdata;

    sysbus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .is_write   (held_write),
        .accept     (accept),
        .busy       (busy),
        .done       (done),
        .rd_n       (bus_rd_n),
        .wr_n       (bus_wr_n),
        .drive_addr (drive_addr),
        .doe        (doe_i),
        .capture    (capture)
    );

    sysbus_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .in_write   (req_write),
        .in_io      (req_io),
        .in_addr    (req_addr),
        .in_wdata   (req_wdata),
        .held_write (held_write),
        .held_io    (held_io),
        .held_addr  (held_addr),
        .held_wdata (held_wdata)
    );

    sysbus_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (bus_din),
        .dout    (rd_data)
    );

    assign bus_addr = drive_addr ? held_addr : '0;
    assign bus_io_m = drive_addr & held_io;
    assign bus_doe  = doe_i;
    assign bus_dout = doe_i ? held_wdata : '0;
endmodule

// File: rtl/sysbus_master_chk.sv
module sysbus_master_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_doe,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_io_m
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_rd_n && bus_wr_n && !bus_doe && !bus_io_m && bus_addr == '0));

    assert_addr_before_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n) |-> ($stable(bus_addr) && $past(busy)));

    assert_lines_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> ($stable(bus_io_m) && $stable(bus_addr)));

    assert_no_dual_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_ends_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    assert_wr_with_doe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> bus_doe);
endmodule

bind sysbus_master sysbus_master_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .bus_addr (bus_addr),
    .bus_doe  (bus_doe),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_io_m (bus_io_m)
);

// File: tb/sysbus_master_test.sv
module sysbus_master_test;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, done, bus_doe, bus_rd_n, bus_wr_n, bus_io_m;
    logic [DW-1:0] rd_data, bus_dout, bus_din;
    logic [AW-1:0] bus_addr;

    logic [DW-1:0] mem_sp [N];
    logic [DW-1:0] io_sp  [N];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sysbus_master #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_io_m(bus_io_m)
    );

    // responder: data only while read strobe low, otherwise a filler pattern
    assign bus_din = !bus_rd_n ? (bus_io_m ? io_sp[bus_addr] : mem_sp[bus_addr]) : 8'h5A;

    always @(posedge clk) begin
        if (rst_n && !bus_wr_n) begin
            if (bus_io_m) io_sp[bus_addr]  <= bus_dout;
            else          mem_sp[bus_addr] <= bus_dout;
        end
    end

    function automatic logic [DW-1:0] init_val(bit io, int a);
        return io ? DW'(a * 29 + 65) : DW'(a * 7 + 3);
    endfunction

    function automatic logic [DW-1:0] wr_val(bit io, int a);
        return io ? DW'(a * 5 + 23) : DW'(a * 11 + 144);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished)
            chk(!(!bus_rd_n && !bus_wr_n), "R6", "both strobes low",
                {bus_rd_n, bus_wr_n}, 3);
    end

    task automatic chk_idle(string tag);
        chk(bus_rd_n && bus_wr_n, "R1", {tag, " strobes"}, {bus_rd_n, bus_wr_n}, 3);
        chk(!bus_doe && bus_dout == 0, "R1", {tag, " data lines"}, {bus_doe, bus_dout}, 0);
        chk(bus_addr == 0 && !bus_io_m, "R1", {tag, " addr/iom"}, {bus_io_m, bus_addr}, 0);
        chk(!busy && !done, "R1", {tag, " busy/done"}, {busy, done}, 0);
    endtask

    // starts and ends at a falling edge with the block idle
    task automatic xfer(bit w, bit io, int a, logic [DW-1:0] d, logic [DW-1:0] exp_rd, bit hold);
        logic [AW-1:0] ea = AW'(a);
        logic [DW-1:0] prev_rd = rd_data;
        req_valid = 1'b1; req_write = w; req_io = io; req_addr = ea; req_wdata = d;
        @(negedge clk); // address cycle
        if (hold) begin
            req_addr = ea ^ 4'h5; req_write = !w; req_io = !io; req_wdata = ~d;
        end else req_valid = 1'b0;
        chk(busy && !done, "R7", "address cycle busy", {busy, done}, 2);
        chk(bus_addr == ea, w ? "R4" : "R2", "address cycle addr", bus_addr, ea);
        chk(bus_rd_n && bus_wr_n, "R2", "address cycle strobes", {bus_rd_n, bus_wr_n}, 3);
        chk(bus_io_m == io, "R5", "address cycle io_m", bus_io_m, io);
        chk(bus_doe == w, "R10", "address cycle doe", bus_doe, w);
        if (w) chk(bus_dout == d, "R4", "address cycle dout", bus_dout, d);
        @(negedge clk); // strobe cycle
        req_valid = 1'b0;
        chk(bus_addr == ea, hold ? "R8" : "R2", "strobe cycle addr", bus_addr, ea);
        chk(bus_io_m == io, hold ? "R8" : "R5", "strobe cycle io_m", bus_io_m, io);
        chk(bus_rd_n == w && bus_wr_n == !w, w ? "R4" : "R2", "strobe cycle strobes",
            {bus_rd_n, bus_wr_n}, {w, !w});
        chk(bus_doe == w, "R10", "strobe cycle doe", bus_doe, w);
        if (w) chk(bus_dout == d, "R4", "strobe cycle dout", bus_dout, d);
        chk(busy && !done, "R7", "strobe cycle busy", {busy, done}, 2);
        @(negedge clk); // done cycle
        chk(busy && done, "R7", "done cycle", {busy, done}, 3);
        chk(bus_rd_n && bus_wr_n && !bus_doe && bus_addr == 0 && bus_dout == 0,
            w ? "R4" : "R3", "done cycle released",
            {bus_rd_n, bus_wr_n, bus_doe, bus_addr, bus_dout}, 6 << (AW + DW));
        if (w) chk(rd_data == prev_rd, "R9", "rd_data after write", rd_data, prev_rd);
        else   chk(rd_data == exp_rd, "R3", "read data", rd_data, exp_rd);
        @(negedge clk); // idle again
        chk(!busy && !done, hold ? "R8" : "R7", "back to idle", {busy, done}, 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mem_sp[i] = init_val(1'b0, i);
            io_sp[i]  = init_val(1'b1, i);
        end
        repeat (3) @(negedge clk);
        chk_idle("in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("after reset");

        // read sweep of both spaces with initial contents
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < N; a++)
                xfer(1'b0, s[0], a, 8'h00, init_val(s[0], a), 1'b0);

        // write sweep, then read back; the other space must keep its pattern
        for (int a = 0; a < N; a++)
            xfer(1'b1, 1'b0, a, wr_val(1'b0, a), 8'h00, 1'b0);
        for (int a = 0; a < N; a++)
            xfer(1'b0, 1'b1, a, 8'h00, init_val(1'b1, a), 1'b0);
        for (int a = 0; a < N; a++)
            xfer(1'b1, 1'b1, a, wr_val(1'b1, a), 8'h00, 1'b0);
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < N; a++)
                xfer(1'b0, s[0], a, 8'h00, wr_val(s[0], a), 1'b0);

        // request held and changed while busy
        xfer(1'b0, 1'b0, 3, 8'h00, wr_val(1'b0, 3), 1'b1);
        chk_idle("after held read");
        xfer(1'b1, 1'b1, 9, 8'hC3, 8'h00, 1'b1);
        chk(io_sp[9] == 8'hC3, "R8", "held write landed", io_sp[9], 8'hC3);
        chk(io_sp[9 ^ 5] == wr_val(1'b1, 9 ^ 5), "R8", "no stray write",
            io_sp[9 ^ 5], wr_val(1'b1, 9 ^ 5));
        chk(mem_sp[9] == wr_val(1'b0, 9), "R5", "memory space untouched",
            mem_sp[9], wr_val(1'b0, 9));
        chk_idle("end");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule